// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block is the host side of a three-wire link to a serial sampling converter. On a start command it raises the conversion-start line for one serial-clock period. It then emits 32 serial-clock periods and shifts the returned data line into a 32-bit word, which it presents with a one-cycle valid strobe. The serial-clock half period is set in system-clock cycles by a divider input.

The same two output lines are also used to request the converter's low-power states. A nap request is a burst of two conversion-start pulses with the serial clock parked low. A sleep request is a burst of four such pulses. The wake command picks its sequence from the power state the controller has recorded. From nap it sends a single serial-clock period. From sleep it sends a clock period, a nap burst and a second clock period, then holds off for a programmable settling time while the converter's reference recovers.

Commands arrive on a valid/code pair. A command is taken only when the controller is idle and the command is legal for the recorded power state. Any other command is discarded and answered with a one-cycle error pulse.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is held, and after its release, the outputs `conv_o`, `sck_o`, `busy`, `res_valid` and `cmd_err` are all low, and the recorded power state is active.
- R2: Command code 0 (start) in the active state produces one frame. `conv_o` is high for exactly 2·H system cycles with `sck_o` low. It is followed by 32 serial-clock periods, each high for H cycles and then low for H cycles. The first rising edge of `sck_o` occurs on the clock edge at which `conv_o` falls, and `sck_o` never rises while `conv_o` is high.
- R3: `sdo_in` is sampled on every rising edge of `sck_o`, and the first sample is placed at bit 31 of `res_data`. `res_valid` is high for exactly one cycle, on the cycle `sck_o` becomes high for the 32nd time. In that cycle `res_data` holds the complete word.
- R4: Command code 1 (nap) produces exactly two `conv_o` pulses of 2·H cycles each, with no rising edge on `sck_o`.
- R5: Command code 2 (sleep) produces exactly four `conv_o` pulses of 2·H cycles each, with no rising edge on `sck_o`.
- R6: Between two pulses of one power burst, `conv_o` stays low for exactly max(2·H, `CONV_LOW_MIN`) cycles. `conv_o` never rises before it has been low for `CONV_LOW_MIN` cycles.
- R7: Command code 3 (wake) in the nap state produces one serial-clock period and no `conv_o` pulse, and returns the state to active. A start command is then accepted.
- R8: Wake in the sleep state produces one serial-clock period, two `conv_o` pulses and a second serial-clock period. `busy` then stays high for H + `settle_cfg` + 1 cycles after the final fall of `sck_o`. A start command during that window is refused, and a start command after it is accepted.
- R9: A command presented while `busy` is high is dropped. `cmd_err` pulses high for one cycle, on the cycle after the command, and the frame in progress completes unchanged.
- R10: A start command in the nap or sleep state, and a nap or sleep command in the sleep state, are refused with a `cmd_err` pulse and cause no activity on `conv_o` or `sck_o`.
- R11: H equals `div_cfg`, and a `div_cfg` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 2 | 0 start, 1 nap, 2 sleep, 3 wake |
| div_cfg | input | DIV_W | Serial-clock half period in system cycles (0 means 1) |
| settle_cfg | input | SETTLE_W | Settling wait after a wake from sleep, in system cycles |
| sdo_in | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion-start line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| busy | output | 1 | High when a new command would be refused for timing reasons |
| cmd_err | output | 1 | One-cycle pulse for a dropped or refused command |
| res_valid | output | 1 | One-cycle pulse when a 32-bit frame has been captured |
| res_data | output | FRAME_BITS | Captured frame, first bit received at the top |

## Verification
The bench measures pulse widths, low gaps and edge counts at the ports against the H the divider should give, including the divider value 0. A controller that uses the divider setting one-to-one, or that forgets to treat 0 as 1, shows a wrong conversion-start width. The low gap inside power bursts is checked at a divider where the fixed minimum dominates and at one where the two-half-period rule dominates, so a gap rule that drops either term is caught. The wake-from-sleep path is timed from the last serial-clock fall to the drop of `busy`, with a start command pushed in mid-wait. An off-by-one in the settle counter, or a controller that skips the inner nap burst, fails there. Commands sent during a frame, and start or nap commands sent from the wrong power state, must raise exactly one error pulse while the captured word stays bit-exact.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_NAP   = 2'd1,
    CMD_SLEEP = 2'd2,
    CMD_WAKE  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_NAP    = 2'd1,
    PM_SLEEP  = 2'd2
  } pm_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CONV   = 3'd1,
    ST_GAP    = 3'd2,
    ST_SHI    = 3'd3,
    ST_SLO    = 3'd4,
    ST_WHI    = 3'd5,
    ST_WLO    = 3'd6,
    ST_SETTLE = 3'd7
  } st_e;

endpackage

// File: rtl/adcf_tick.sv
// Half-period tick generator for the serial clock.
module adcf_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  // A divider value of zero behaves as one (R11)
  always_comb begin
    half = (div_cfg == '0) ? DIV_W'(1) : div_cfg;
    tick = (cnt_q == half - DIV_W'(1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)) else $error("tick counter not restarted"); // R11

endmodule

// File: rtl/adcf_shift.sv
// Receive shifter: MSB-first capture and the frame-done strobe.
module adcf_shift #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift_en,
  input  logic                  sdo_in,
  output logic                  res_valid,
  output logic [FRAME_BITS-1:0] res_data
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] data_q, data_d;
  logic                  vld_q, vld_d;
  logic                  last_bit;

  always_comb begin
    last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));
    cnt_d    = cnt_q;
    data_d   = data_q;
    vld_d    = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      data_d = {data_q[FRAME_BITS-2:0], sdo_in};
      cnt_d  = cnt_q + CNT_W'(1);
      vld_d  = last_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      if (shift_en) data_q <= data_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = data_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid) else $error("valid longer than one cycle"); // R3
  AST_VALID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cnt_q == CNT_W'(FRAME_BITS))) else $error("valid before full frame"); // R3

endmodule

// File: rtl/adcf_seq.sv
// Frame, power-burst and wake sequencer.
module adcf_seq
  import adcf_pkg::*;
#(
  parameter int FRAME_BITS   = 32,
  parameter int CONV_LOW_MIN = 6,
  parameter int SETTLE_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  input  logic [SETTLE_W-1:0] settle_cfg,
  input  logic                tick,
  output logic                tick_clr,
  output logic                shift_en,
  output logic                frame_clr,
  output logic                conv_o,
  output logic                sck_o,
  output logic                busy,
  output logic                cmd_err
);

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int LOW_W = $clog2(CONV_LOW_MIN + 1);

  st_e                 state_q, state_n;
  cmd_e                op_q, op_n;
  pm_e                 pm_q, pm_n;
  logic [1:0]          ph_q, ph_n;
  logic [2:0]          left_q, left_n;
  logic [BIT_W-1:0]    bits_q, bits_n;
  logic                wstg_q, wstg_n;
  logic [SETTLE_W-1:0] stl_q, stl_n;
  logic [LOW_W-1:0]    low_q, low_n;
  logic                conv_q, conv_n;
  logic                sck_q, sck_n;
  logic                err_q, err_n;

  cmd_e cmd;
  logic low_ok, idle_ok, legal, accept, gap_done;

  // Command qualification
  always_comb begin
    cmd     = cmd_e'(cmd_code);
    low_ok  = (low_q >= LOW_W'(CONV_LOW_MIN - 1));
    idle_ok = (state_q == ST_IDLE) && low_ok;
    unique case (cmd)
      CMD_START: legal = (pm_q == PM_ACTIVE);
      CMD_NAP,
      CMD_SLEEP: legal = (pm_q != PM_SLEEP);
      default:   legal = 1'b1;
    endcase
    accept   = cmd_valid && idle_ok && legal;
    gap_done = ((ph_q == 2'd2) || ((ph_q == 2'd1) && tick)) && low_ok;
  end

  // Next-state logic
  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    pm_n    = pm_q;
    left_n  = left_q;
    bits_n  = bits_q;
    wstg_n  = wstg_q;
    stl_n   = stl_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_n = cmd;
          unique case (cmd)
            CMD_START: begin state_n = ST_CONV; left_n = 3'd1; end
            CMD_NAP:   begin state_n = ST_CONV; left_n = 3'd2; end
            CMD_SLEEP: begin state_n = ST_CONV; left_n = 3'd4; end
            default:   begin state_n = ST_WHI;  wstg_n = 1'b0; end
          endcase
        end
      end
      ST_CONV: begin
        if (tick && (ph_q == 2'd1)) begin
          left_n = left_q - 3'd1;
          if (op_q == CMD_START) begin
            state_n = ST_SHI;
            bits_n  = '0;
          end else begin
            state_n = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          if (left_q != 3'd0) begin
            state_n = ST_CONV;
          end else begin
            unique case (op_q)
              CMD_NAP:   begin state_n = ST_IDLE; pm_n = PM_NAP;   end
              CMD_SLEEP: begin state_n = ST_IDLE; pm_n = PM_SLEEP; end
              default:   begin state_n = ST_WHI;  wstg_n = 1'b1;   end
            endcase
          end
        end
      end
      ST_SHI: begin
        if (tick) state_n = ST_SLO;
      end
      ST_SLO: begin
        if (tick) begin
          if (bits_q == BIT_W'(FRAME_BITS - 1)) begin
            state_n = ST_IDLE;
          end else begin
            bits_n  = bits_q + BIT_W'(1);
            state_n = ST_SHI;
          end
        end
      end
      ST_WHI: begin
        if (tick) state_n = ST_WLO;
      end
      ST_WLO: begin
        if (tick) begin
          if ((pm_q == PM_SLEEP) && !wstg_q) begin
            if (low_ok) begin
              state_n = ST_CONV;
              left_n  = 3'd2;
            end
          end else if (pm_q == PM_SLEEP) begin
            state_n = ST_SETTLE;
            stl_n   = settle_cfg;
            pm_n    = PM_ACTIVE;
          end else begin
            state_n = ST_IDLE;
            pm_n    = PM_ACTIVE;
          end
        end
      end
      ST_SETTLE: begin
        if (stl_q == '0) state_n = ST_IDLE;
        else             stl_n   = stl_q - SETTLE_W'(1);
      end
      default: state_n = ST_IDLE;
    endcase

    if (state_n != state_q)               ph_n = 2'd0;
    else if (tick && (ph_q != 2'd2))      ph_n = ph_q + 2'd1;
    else                                  ph_n = ph_q;

    conv_n = (state_n == ST_CONV);
    sck_n  = (state_n == ST_SHI) || (state_n == ST_WHI);
    err_n  = cmd_valid && !accept;

    if (conv_q)                             low_n = '0;
    else if (low_q == LOW_W'(CONV_LOW_MIN)) low_n = low_q;
    else                                    low_n = low_q + LOW_W'(1);
  end

  // Strobes to the tick generator and the shifter
  always_comb begin
    tick_clr  = (state_n != state_q) || (state_q == ST_IDLE);
    shift_en  = (state_n == ST_SHI) && (state_q != ST_SHI);
    frame_clr = accept && (cmd == CMD_START);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= CMD_START;
      pm_q    <= PM_ACTIVE;
      ph_q    <= 2'd0;
      left_q  <= 3'd0;
      bits_q  <= '0;
      wstg_q  <= 1'b0;
      stl_q   <= '0;
      low_q   <= LOW_W'(CONV_LOW_MIN);
      conv_q  <= 1'b0;
      sck_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      pm_q    <= pm_n;
      ph_q    <= ph_n;
      left_q  <= left_n;
      bits_q  <= bits_n;
      wstg_q  <= wstg_n;
      stl_q   <= stl_n;
      low_q   <= low_n;
      conv_q  <= conv_n;
      sck_q   <= sck_n;
      err_q   <= err_n;
    end
  end

  assign conv_o  = conv_q;
  assign sck_o   = sck_q;
  assign busy    = !idle_ok;
  assign cmd_err = err_q;

  AST_NO_SCK_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> !conv_q) else $error("serial clock rose with start high"); // R2
  AST_BURST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CONV) || (state_q == ST_GAP)) |-> !sck_q) else $error("clock in burst"); // R4
  AST_CONV_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_q) |-> ($past(low_q) >= LOW_W'(CONV_LOW_MIN - 1))) else $error("start low too short"); // R6
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (!conv_q && !sck_q && busy)) else $error("activity while settling"); // R8

endmodule

// File: rtl/adc_frame_ctrl.sv
// Top: reset synchronizer, tick generator, sequencer, receive shifter.
module adc_frame_ctrl #(
  parameter int DIV_W        = 8,
  parameter int SETTLE_W     = 16,
  parameter int FRAME_BITS   = 32,
  parameter int CONV_LOW_MIN = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_code,
  input  logic [DIV_W-1:0]      div_cfg,
  input  logic [SETTLE_W-1:0]   settle_cfg,
  input  logic                  sdo_in,
  output logic                  conv_o,
  output logic                  sck_o,
  output logic                  busy,
  output logic                  cmd_err,
  output logic                  res_valid,
  output logic [FRAME_BITS-1:0] res_data
);

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       tick, tick_clr, shift_en, frame_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  adcf_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_s),
    .clr     (tick_clr),
    .div_cfg (div_cfg),
    .tick    (tick)
  );

  adcf_seq #(
    .FRAME_BITS   (FRAME_BITS),
    .CONV_LOW_MIN (CONV_LOW_MIN),
    .SETTLE_W     (SETTLE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .settle_cfg (settle_cfg),
    .tick       (tick),
    .tick_clr   (tick_clr),
    .shift_en   (shift_en),
    .frame_clr  (frame_clr),
    .conv_o     (conv_o),
    .sck_o      (sck_o),
    .busy       (busy),
    .cmd_err    (cmd_err)
  );

  adcf_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s),
    .clr       (frame_clr),
    .shift_en  (shift_en),
    .sdo_in    (sdo_in),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  AST_ERR_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_err |-> $past(cmd_valid)) else $error("error without a command"); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_err && !$past(cmd_valid, 2)) |=> !cmd_err) else $error("error pulse stretched"); // R10

endmodule

// File: tb/test_adc_frame_ctrl.sv
module test_adc_frame_ctrl;

  localparam int DIV_W = 8, SETTLE_W = 16, FB = 32, LOWMIN = 6;
  localparam int NVEC = 4;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1, 32'hA5C3_0F81},
    {8'd3, 32'h8000_0001},
    {8'd2, 32'h7FFF_FFFE},
    {8'd0, 32'h1234_5678}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic [DIV_W-1:0] div_cfg = 8'd1;
  logic [SETTLE_W-1:0] settle_cfg = 16'd40;
  logic sdo_in;
  logic conv_o, sck_o, busy, cmd_err, res_valid;
  logic [FB-1:0] res_data;

  always #4 clk = ~clk;

  adc_frame_ctrl #(.DIV_W(DIV_W), .SETTLE_W(SETTLE_W), .FRAME_BITS(FB),
                   .CONV_LOW_MIN(LOWMIN)) i_adc_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .div_cfg(div_cfg), .settle_cfg(settle_cfg), .sdo_in(sdo_in),
    .conv_o(conv_o), .sck_o(sck_o), .busy(busy), .cmd_err(cmd_err),
    .res_valid(res_valid), .res_data(res_data));

  int n_chk = 0, n_bad = 0;
  int clr_req = 0, clr_seen = 0;
  logic [FB-1:0] cur_word = '0;
  int n_conv, n_sck, n_valid, n_err, sck_in_conv;
  int hi_run, lo_run, conv_hi_w, lo_min, sk_run, sck_hi_w, idx;
  bit lo_valid, valid_at_32, pconv, psck;
  logic [FB-1:0] cap;

  // Port monitor and converter data model, sampled on the falling edge
  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req;
      n_conv = 0; n_sck = 0; n_valid = 0; n_err = 0; sck_in_conv = 0;
      conv_hi_w = 0; lo_min = 9999; sck_hi_w = 0; lo_valid = 0;
      valid_at_32 = 0; cap = '0;
    end
    if (conv_o) begin
      if (!pconv) begin
        n_conv++;
        if (lo_valid && lo_run < lo_min) lo_min = lo_run;
        hi_run = 0;
      end
      hi_run++;
    end else begin
      if (pconv) begin conv_hi_w = hi_run; lo_run = 0; lo_valid = 1; end
      lo_run++;
    end
    if (sck_o) begin
      if (!psck) begin n_sck++; sk_run = 0; if (conv_o) sck_in_conv++; end
      sk_run++;
    end else if (psck) begin
      sck_hi_w = sk_run;
    end
    if (conv_o) idx = 0;
    else if (sck_o && !psck) idx++;
    sdo_in = (idx < FB) ? cur_word[FB-1-idx] : 1'b0;
    if (res_valid) begin
      n_valid++;
      cap = res_data;
      valid_at_32 = sck_o && (n_sck == 32);
    end
    if (cmd_err) n_err++;
    pconv = conv_o;
    psck = sck_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    clr_req++;
  endtask

  task automatic send(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    @(negedge clk);
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R2", "idle timeout", t, 0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    int h, cnt, falls;
    pconv = 0; psck = 0; idx = 0; hi_run = 0; lo_run = 0; sk_run = 0;
    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk(!conv_o && !sck_o, "R1", "lines in reset", {conv_o, sck_o}, 0);
    chk(!busy && !res_valid && !cmd_err, "R1", "flags in reset",
        {busy, res_valid, cmd_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !conv_o && !sck_o, "R1", "after release",
        {busy, conv_o, sck_o}, 0);

    // Frame table (R2, R3, R11)
    for (int v = 0; v < NVEC; v++) begin
      div_cfg = VEC[v][39:32];
      cur_word = VEC[v][31:0];
      h = (div_cfg == 0) ? 1 : int'(div_cfg);
      clr_mon();
      send(2'd0);
      wait_idle();
      chk(conv_hi_w == 2*h, "R2", "start width", conv_hi_w, 2*h);
      chk(n_conv == 1, "R2", "start pulses", n_conv, 1);
      chk(n_sck == 32, "R2", "clock rises", n_sck, 32);
      chk(sck_hi_w == h, "R11", "clock high width", sck_hi_w, h);
      chk(sck_in_conv == 0, "R2", "rise while start high", sck_in_conv, 0);
      chk(cap == cur_word, "R3", "captured word", cap, cur_word);
      chk(n_valid == 1 && valid_at_32, "R3", "valid pulse", n_valid, 1);
    end

    // Nap burst at H=1: fixed minimum dominates the gap (R4, R6)
    div_cfg = 8'd1;
    clr_mon(); send(2'd1); wait_idle();
    chk(n_conv == 2 && n_sck == 0, "R4", "nap burst", {n_conv, n_sck}, 2 << 32);
    chk(lo_min == LOWMIN, "R6", "gap at H=1", lo_min, LOWMIN);
    chk(conv_hi_w == 2, "R4", "nap pulse width", conv_hi_w, 2);
    // Start refused while napping (R10)
    clr_mon(); send(2'd0); repeat (4) @(negedge clk);
    chk(n_err == 1 && n_conv == 0 && n_sck == 0, "R10", "start in nap",
        n_err, 1);
    // Wake from nap (R7)
    clr_mon(); send(2'd3); wait_idle();
    chk(n_sck == 1 && n_conv == 0, "R7", "nap wake edges", n_sck, 1);
    cur_word = 32'hC001_D00D;
    clr_mon(); send(2'd0); wait_idle();
    chk(n_err == 0 && cap == cur_word, "R7", "frame after wake", cap, cur_word);

    // Sleep burst at H=4: half-period rule dominates the gap (R5, R6)
    div_cfg = 8'd4;
    clr_mon(); send(2'd2); wait_idle();
    chk(n_conv == 4 && n_sck == 0, "R5", "sleep burst", n_conv, 4);
    chk(conv_hi_w == 8, "R5", "sleep pulse width", conv_hi_w, 8);
    chk(lo_min == 8, "R6", "gap at H=4", lo_min, 8);
    // Nap refused while asleep (R10)
    clr_mon(); send(2'd1); repeat (4) @(negedge clk);
    chk(n_err == 1 && n_conv == 0, "R10", "nap in sleep", n_err, 1);

    // Wake from sleep with settle, start pushed mid-wait (R8)
    div_cfg = 8'd2;
    clr_mon();
    send(2'd3);
    cnt = 0; falls = 0; psck_loc_loop: begin
      bit ps;
      ps = sck_o;
      for (int t = 0; t < 3000 && busy; t++) begin
        if (ps && !sck_o) begin falls++; cnt = 1; end
        else cnt++;
        if (falls == 2 && cnt == 10) begin cmd_valid = 1'b1; cmd_code = 2'd0; end
        else cmd_valid = 1'b0;
        ps = sck_o;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    chk(cnt == 2 + 40 + 1, "R8", "settle busy cycles", cnt, 43);
    chk(n_conv == 2 && n_sck == 2, "R8", "sleep wake edges",
        {n_conv, n_sck}, 64'h2_0000_0002);
    chk(n_err == 1, "R8", "start during settle", n_err, 1);
    cur_word = 32'h0F0F_55AA;
    clr_mon(); send(2'd0); wait_idle();
    chk(cap == cur_word && n_valid == 1, "R8", "frame after settle", cap, cur_word);

    // Command during a frame is dropped (R9)
    div_cfg = 8'd3;
    cur_word = 32'hDEAD_BEEF;
    clr_mon(); send(2'd0);
    repeat (10) @(negedge clk);
    send(2'd1);
    wait_idle();
    chk(n_err == 1, "R9", "error pulses", n_err, 1);
    chk(n_conv == 1 && n_sck == 32, "R9", "frame intact", n_sck, 32);
    chk(cap == cur_word, "R9", "word intact", cap, cur_word);

    finish_up();
  end

endmodule